// File: doc/BRIEF.md
# Shared Store-Busy Line Controller

This block sits beside a nonvolatile SRAM controller and manages a shared, active-low busy/request line that several memory devices wire together. Any device may pull the line low to call for a save of SRAM contents into nonvolatile cells. The block watches that line through a synchronizer and also accepts a local power-fail request. In both cases it opens a grace window of a fixed number of clock cycles. Reads continue during the window, writes already accepted may finish, and any new write is refused.

When the window closes, the block starts a STORE through a single-cycle handshake if the SRAM has been written since the last nonvolatile cycle. If it has not, the request is taken and nothing is programmed. While its own STORE runs, the block pulls the shared line low, and it releases the line on the done handshake. It then keeps the SRAM disabled until it sees the line high again. The block only ever enables a pull-down and never drives the line high, so devices can share the line as an open-drain wired-AND.

Top module: `store_busy_ctrl`

## Requirements
- R1: After reset the line pull-down is off, writes are not inhibited, the SRAM is not disabled and store_start is low.
- R2: A low level on busy_line_in that stays low is acted on after the SYNC_STAGES synchronizer plus one state register. With the default of 2 stages, wr_inhibit rises at the third rising edge after the line falls.
- R3: The grace window lasts exactly GRACE_CYC cycles. store_start (or, for a clean SRAM, the exit from the window) follows GRACE_CYC cycles after wr_inhibit rises.
- R4: During the grace window, reads are still granted (acc_grant high for acc_req with acc_wr low) and sram_disable is low. Writes are refused (acc_grant low for acc_req with acc_wr high).
- R5: store_start is a single-cycle pulse. It fires only if a write was granted since the last completed STORE or RECALL.
- R6: line_pull_en is high from the store_start cycle until store_done is sampled, and it drops in the following cycle.
- R7: If the SRAM is clean, the window ends with no store_start, and the block does not pull the line for the STORE.
- R8: After the window or the STORE ends, sram_disable stays high while the synchronized line is low. It clears on the third rising edge after the line goes high.
- R9: A rising edge on pwr_fail_req starts the sequence one edge later with no line activity. The block pulls the line low for the whole grace window so that other devices join in.
- R10: A granted write sets the dirty state. store_done during a STORE clears it, and so does recall_done. If a granted write and recall_done fall in the same cycle, the dirty state stays set.
- R11: A level held high on pwr_fail_req does not start a second sequence. Only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_line_in | input | 1 | Sampled level of the shared active-low line |
| line_pull_en | output | 1 | Enables the open-drain pull-down on the shared line |
| pwr_fail_req | input | 1 | Local power-fail request, acted on at its rising edge |
| acc_req | input | 1 | SRAM access requested this cycle |
| acc_wr | input | 1 | The requested access is a write |
| acc_grant | output | 1 | The requested access may proceed |
| wr_inhibit | output | 1 | New writes are refused |
| sram_disable | output | 1 | All SRAM accesses are refused |
| store_start | output | 1 | One-cycle pulse that launches a STORE |
| store_done | input | 1 | The STORE engine has finished |
| recall_done | input | 1 | A RECALL has finished; the SRAM now matches nonvolatile data |

## Verification
Two functions can meet in one cycle: a write being granted, which marks the SRAM dirty, and a recall_done pulse, which marks it clean. The bench raises a write request and recall_done on the same clock edge, then triggers the shared line. The bench judges the result by whether store_start appears after the grace window: set must win, so the STORE has to happen. A separate case with recall_done alone confirms that the clear works when nothing competes with it.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GRACE   = 2'd1,
        ST_STORE   = 2'd2,
        ST_WAIT_HI = 2'd3
    } sbc_state_e;

    typedef struct packed {
        logic req;
        logic wr;
    } sbc_access_t;

    function automatic logic blocks_all(input sbc_state_e s);
        return (s == ST_STORE) || (s == ST_WAIT_HI);
    endfunction

    function automatic logic blocks_writes(input sbc_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/sbc_line_sync.sv
module sbc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_raw,
    output logic line_low
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= line_raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], line_raw};
            end
        end
    endgenerate

    assign line_low = ~chain_q[STAGES-1];
endmodule

// File: rtl/sbc_grace_timer.sv
module sbc_grace_timer #(
    parameter int GRACE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(GRACE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(GRACE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == LAST);

    // R3
    fresh_window_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !$past(run)) |-> (cnt_q == '0));

    // R3
    bounded_count_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= LAST));
endmodule

// File: rtl/sbc_dirty_track.sv
module sbc_dirty_track (
    input  logic clk,
    input  logic rst,
    input  logic wr_accept,
    input  logic store_fin,
    input  logic recall_fin,
    output logic dirty
);
    logic dirty_q;

    always_ff @(posedge clk) begin
        if (rst)                          dirty_q <= 1'b0;
        else if (wr_accept)               dirty_q <= 1'b1;
        else if (store_fin || recall_fin) dirty_q <= 1'b0;
    end

    assign dirty = dirty_q;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && recall_fin) |=> dirty);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_accept && (store_fin || recall_fin)) |=> !dirty);
endmodule

// File: rtl/store_busy_ctrl.sv
module store_busy_ctrl
    import sbc_pkg::*;
#(
    parameter int GRACE_CYC   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_line_in,
    output logic line_pull_en,
    input  logic pwr_fail_req,
    input  logic acc_req,
    input  logic acc_wr,
    output logic acc_grant,
    output logic wr_inhibit,
    output logic sram_disable,
    output logic store_start,
    input  logic store_done,
    input  logic recall_done
);
    sbc_state_e  state_q, state_d;
    sbc_access_t acc;
    logic line_low, pf_prev_q, pf_edge, expire, dirty;
    logic own_q, own_d, start_q, start_d, wr_accept, store_fin;

    assign acc = '{req: acc_req, wr: acc_wr};

    sbc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .line_raw(busy_line_in), .line_low(line_low));

    sbc_grace_timer #(.GRACE_CYC(GRACE_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(state_q == ST_GRACE), .expire(expire));

    assign wr_accept = acc.req && acc.wr && !blocks_writes(state_q);
    assign store_fin = (state_q == ST_STORE) && store_done;

    sbc_dirty_track u_dirty (
        .clk(clk), .rst(rst), .wr_accept(wr_accept), .store_fin(store_fin),
        .recall_fin(recall_done), .dirty(dirty));

    assign pf_edge = pwr_fail_req && !pf_prev_q;

    always_comb begin
        state_d = state_q;
        own_d   = own_q;
        start_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (line_low || pf_edge) begin
                    state_d = ST_GRACE;
                    own_d   = pf_edge;
                end
            end
            ST_GRACE: begin
                if (expire) begin
                    own_d = 1'b0;
                    if (dirty) begin
                        state_d = ST_STORE;
                        start_d = 1'b1;
                    end else begin
                        state_d = ST_WAIT_HI;
                    end
                end
            end
            ST_STORE:   if (store_done) state_d = ST_WAIT_HI;
            ST_WAIT_HI: if (!line_low)  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            own_q     <= 1'b0;
            start_q   <= 1'b0;
            pf_prev_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            own_q     <= own_d;
            start_q   <= start_d;
            pf_prev_q <= pwr_fail_req;
        end
    end

    assign line_pull_en = (state_q == ST_STORE) || ((state_q == ST_GRACE) && own_q);
    assign wr_inhibit   = blocks_writes(state_q);
    assign sram_disable = blocks_all(state_q);
    assign store_start  = start_q;
    assign acc_grant    = acc.req && !sram_disable && !(acc.wr && wr_inhibit);

    // R2
    line_reacts_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && line_low) |=> wr_inhibit);

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        store_start |=> !store_start);

    // R5
    start_needs_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        store_start |-> $past(dirty));

    // R6
    pull_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        store_start |-> line_pull_en);

    // R8
    hold_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_HI && line_low) |=> sram_disable);

    // R4
    reads_in_grace_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GRACE && acc_req && !acc_wr) |-> acc_grant);

    // R10
    clean_after_store_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_HI && $past(state_q) == ST_STORE) |-> !dirty);
endmodule

// File: tb/store_busy_ctrl_bench.sv
module store_busy_ctrl_bench;
    localparam int G = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic ext_low = 1'b0, pf = 1'b0, acc_req = 1'b0, acc_wr = 1'b0;
    logic store_done = 1'b0, recall_done = 1'b0;
    logic line_pull_en, acc_grant, wr_inhibit, sram_disable, store_start;
    logic busy_line;
    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    assign busy_line = ~(ext_low | line_pull_en);

    store_busy_ctrl #(.GRACE_CYC(G), .SYNC_STAGES(2)) u_store_busy_ctrl (
        .clk(clk), .rst(rst), .busy_line_in(busy_line), .line_pull_en(line_pull_en),
        .pwr_fail_req(pf), .acc_req(acc_req), .acc_wr(acc_wr), .acc_grant(acc_grant),
        .wr_inhibit(wr_inhibit), .sram_disable(sram_disable), .store_start(store_start),
        .store_done(store_done), .recall_done(recall_done));

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic do_write();
        @(negedge clk); acc_req = 1'b1; acc_wr = 1'b1;
        #1 chk(acc_grant == 1'b1, "R10 write grant", acc_grant, 1);
        @(negedge clk); acc_req = 1'b0; acc_wr = 1'b0;
    endtask

    // line released after k edges; IDLE expected on third edge
    task automatic expect_release(input string req);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk(sram_disable == (k < 3), req, sram_disable, int'(k < 3));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(line_pull_en == 0, "R1 pull", line_pull_en, 0);
        chk(wr_inhibit == 0, "R1 inhibit", wr_inhibit, 0);
        chk(sram_disable == 0, "R1 disable", sram_disable, 0);
        chk(store_start == 0, "R1 start", store_start, 0);
    endtask

    task automatic t_ext_dirty();
        int starts = 0;
        do_write();
        ext_low = 1'b1;
        for (int k = 1; k <= 3 + G; k++) begin
            @(negedge clk);
            if (k == 2) chk(wr_inhibit == 0, "R2 not yet", wr_inhibit, 0);
            if (k == 3) begin
                chk(wr_inhibit == 1, "R2 inhibit edge 3", wr_inhibit, 1);
                acc_req = 1'b1; acc_wr = 1'b0;
                #1 chk(acc_grant == 1, "R4 read in grace", acc_grant, 1);
                acc_wr = 1'b1;
                #1 chk(acc_grant == 0, "R4 write refused", acc_grant, 0);
                acc_req = 1'b0; acc_wr = 1'b0;
            end
            if (k > 3 && k < 3 + G) chk(sram_disable == 0, "R4 no disable", sram_disable, 0);
            if (store_start) starts++;
            if (k < 3 + G) chk(line_pull_en == 0, "R6 no pull before store", line_pull_en, 0);
        end
        chk(store_start == 1, "R3 start after window", store_start, 1);
        chk(starts == 1, "R3 start timing", starts, 1);
        chk(line_pull_en == 1, "R6 pull", line_pull_en, 1);
        ext_low = 1'b0;
        @(negedge clk);
        chk(store_start == 0, "R5 pulse", store_start, 0);
        chk(line_pull_en == 1, "R6 held", line_pull_en, 1);
        store_done = 1'b1;
        @(negedge clk); store_done = 1'b0;
        chk(line_pull_en == 0, "R6 released", line_pull_en, 0);
        chk(sram_disable == 1, "R8 disabled", sram_disable, 1);
        expect_release("R8 wait high");
    endtask

    task automatic t_ext_clean_hold();
        int starts = 0, pulls = 0;
        ext_low = 1'b1;
        for (int k = 1; k <= 3 + G + 10; k++) begin
            @(negedge clk);
            starts += store_start; pulls += line_pull_en;
            if (k > 3 + G) chk(sram_disable == 1, "R8 hold while low", sram_disable, 1);
        end
        chk(starts == 0, "R7 no store when clean", starts, 0);
        chk(pulls == 0, "R7 no pull when clean", pulls, 0);
        ext_low = 1'b0;
        expect_release("R8 release after hold");
    endtask

    task automatic t_local(input bit dirty_first);
        int starts = 0;
        if (dirty_first) do_write();
        @(negedge clk); pf = 1'b1;
        for (int k = 1; k <= 1 + G; k++) begin
            @(negedge clk);
            if (k == 1) chk(wr_inhibit == 1, "R9 start", wr_inhibit, 1);
            if (k <= G) chk(line_pull_en == 1, "R9 pull in window", line_pull_en, 1);
            starts += store_start;
        end
        chk(starts == int'(dirty_first), "R9 store per dirty", starts, int'(dirty_first));
        if (dirty_first) begin
            store_done = 1'b1;
            @(negedge clk); store_done = 1'b0;
        end
        chk(line_pull_en == 0, "R9 released", line_pull_en, 0);
        expect_release("R9 back to idle");
        // pf still high: no new sequence
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(wr_inhibit == 0, "R11 level ignored", wr_inhibit, 0);
        end
        pf = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_ext_count(input string req, input int exp_starts);
        int starts = 0;
        ext_low = 1'b1;
        for (int k = 1; k <= 3 + G + 1; k++) begin
            @(negedge clk); starts += store_start;
        end
        chk(starts == exp_starts, req, starts, exp_starts);
        ext_low = 1'b0;
        if (exp_starts != 0) begin
            store_done = 1'b1;
            @(negedge clk); store_done = 1'b0;
        end
        for (int k = 0; k < 4; k++) @(negedge clk);
        chk(sram_disable == 0, "R8 idle again", sram_disable, 0);
    endtask

    task automatic t_recall_clear();
        do_write();
        @(negedge clk); recall_done = 1'b1;
        @(negedge clk); recall_done = 1'b0;
        run_ext_count("R10 recall clears", 0);
    endtask

    task automatic t_collide();
        @(negedge clk); acc_req = 1'b1; acc_wr = 1'b1; recall_done = 1'b1;
        @(negedge clk); acc_req = 1'b0; acc_wr = 1'b0; recall_done = 1'b0;
        run_ext_count("R10 set wins over recall", 1);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ext_dirty();
        t_ext_clean_hold();
        t_local(1'b1);
        t_local(1'b0);
        t_recall_clear();
        t_collide();
        finish_up();
    end
endmodule